// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is the target side of a two-wire serial bus. It watches the open-drain clock and data lines and finds start and stop conditions. It shifts in the address byte after every start and compares the seven address bits with an address that software programs. When software enables it, the all-zero broadcast address also counts as a match. The last bit of the address byte sets the direction of the transfer. A matched read makes the block transmit. A matched write makes it receive.

Bytes move between the bus and the local processor over two one-entry valid/ready channels. Received bytes leave on `rx_data`/`rx_valid`. A byte counts as consumed in the cycle where `rx_valid` and `rx_ready` are both high. Bytes for transmission enter on `tx_data`/`tx_valid`. A byte is taken in the cycle where `tx_valid` and `tx_ready` are both high. The processor can hold back either channel for as long as it likes, because the block holds the clock line low until the channel moves. Both line outputs are drive-low enables. The block never drives a line high.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, `scl_drive_low` and `sda_drive_low` are 0, `rx_valid`, `addr_match`, `gc_hit`, `dir_tx`, `stop_det` and `nack_det` are 0, and `tx_ready` is 1.
- R2: A rise of SDA while SCL is high is a stop. It gives a one-cycle pulse on `stop_det`, and `addr_match`, `gc_hit` and `dir_tx` are 0 in that cycle.
- R3: A fall of SDA while SCL is high is a start. The next eight bits are taken as the address byte, MSB first. The upper seven bits are the address and bit 0 is read (1) or write (0). If the address equals `own_addr` and `ack_en` is 1, the block pulls SDA low through the ninth clock and sets `addr_match`.
- R4: Address 0 matches only while `gc_en` is 1. Such a match also sets `gc_hit`.
- R5: If the address does not match, or `ack_en` is 0, SDA stays released in the ninth clock. The block then ignores the bus until the next start or stop. It raises no `rx_valid` and never stretches SCL.
- R6: In a write transfer, each received byte appears on `rx_data` with `rx_valid`. SCL is held low from the end of the eighth bit until the byte is consumed. The block then acknowledges (SDA low) when `ack_en` is 1 and leaves SDA released when it is 0.
- R7: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` does not change.
- R8: In a read transfer, SCL is held low before each byte until a byte has been accepted on the tx channel. `tx_ready` is 1 exactly when the one-entry transmit holding register is empty. The byte goes out MSB first.
- R9: If the master acknowledges a transmitted byte, the block stretches again for the next one. If the master does not, the block pulses `nack_det`, releases SDA and ignores the bus until a stop or start.
- R10: A repeated start in any state, including the ignoring state, restarts address reception at once.
- R11: If a transmit byte is already held when the block needs it, SCL is held low for no more than two cycles.
- R12: `scl_drive_low` is only ever 1 while `addr_match` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_drive_low | output | 1 | Pull the clock line low |
| sda_drive_low | output | 1 | Pull the data line low |
| own_addr | input | 7 | Programmed target address |
| ack_en | input | 1 | Acknowledge enable |
| gc_en | input | 1 | Respond to address 0 |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Processor consumes the received byte |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Processor offers a byte |
| tx_ready | output | 1 | Transmit holding register empty |
| addr_match | output | 1 | Block selected in the current transfer |
| gc_hit | output | 1 | Selected through the broadcast address |
| dir_tx | output | 1 | Current transfer is a read (block transmits) |
| stop_det | output | 1 | One-cycle pulse on stop |
| nack_det | output | 1 | One-cycle pulse when the master rejects a byte |

## Verification
The transmit channel handshake and the engine's entry into its stretch wait can land in the same clock. A byte written ahead of time must be taken the cycle after the wait begins, so the wait opens and closes almost at once. The bench provokes this by loading the transmit register before the address byte. It then counts the cycles in which `scl_drive_low` is high across the whole byte and checks that the byte comes back intact. It compares this with a run where the byte is written late and the stretch is seen to persist.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX_BITS,
    ST_RX_HOLD,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX_BITS,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prev;

  assign raw = {scl_i, sda_i};

  // one synchroniser chain per line, plus one history flop for edges
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[DEPTH-2:0], raw[g]};
    end
    assign cur[g]  = pipe[DEPTH-2];
    assign prev[g] = pipe[DEPTH-1];
  end

  always_comb begin
    evt.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
    evt.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    evt.scl_rise = cur[1] & ~prev[1];
    evt.scl_fall = ~cur[1] & prev[1];
    evt.sda      = cur[0];
  end
endmodule

// File: rtl/i2c_hold_reg.sv
module i2c_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] data_q;

  assign in_ready  = ~full;
  assign out_valid = full;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full) begin
      full   <= 1'b1;
      data_q <= in_data;
    end else if (full && out_ready) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_evt_t      evt,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_en,
  input  logic          gc_en,
  input  logic          rx_space,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_byte,
  output logic          rx_push,
  output logic [DW-1:0] rx_byte,
  output logic          tx_pop,
  output logic          scl_low,
  output logic          sda_low,
  output logic          addr_match,
  output logic          gc_hit,
  output logic          dir_tx,
  output logic          stop_det,
  output logic          nack_det
);
  localparam int            CW      = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(DW);
  localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

  tgt_state_e    state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic          hit_own;
  logic          hit_gc;

  assign hit_own = (shreg[DW-1 -: AW] == own_addr);
  assign hit_gc  = gc_en && (shreg[DW-1 -: AW] == '0);

  assign rx_byte = shreg;
  assign rx_push = (state == ST_RX_BITS) && evt.scl_fall && (bitcnt == LAST_RX) && rx_space;
  assign tx_pop  = (state == ST_TX_WAIT) && tx_avail;
  assign scl_low = (state == ST_TX_WAIT) || (state == ST_RX_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      sda_low    <= 1'b0;
      addr_match <= 1'b0;
      gc_hit     <= 1'b0;
      dir_tx     <= 1'b0;
      stop_det   <= 1'b0;
      nack_det   <= 1'b0;
    end else begin
      stop_det <= 1'b0;
      nack_det <= 1'b0;
      if (evt.stop) begin
        state      <= ST_IDLE;
        sda_low    <= 1'b0;
        addr_match <= 1'b0;
        gc_hit     <= 1'b0;
        dir_tx     <= 1'b0;
        stop_det   <= 1'b1;
      end else if (evt.start) begin
        state      <= ST_ADDR;
        bitcnt     <= '0;
        sda_low    <= 1'b0;
        addr_match <= 1'b0;
        gc_hit     <= 1'b0;
        dir_tx     <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (evt.scl_rise) begin
              shreg  <= {shreg[DW-2:0], evt.sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (evt.scl_fall && bitcnt == LAST_RX) begin
              if ((hit_own || hit_gc) && ack_en) begin
                sda_low    <= 1'b1;
                addr_match <= 1'b1;
                gc_hit     <= hit_gc;
                dir_tx     <= shreg[0];
                state      <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (evt.scl_fall) begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
              state   <= dir_tx ? ST_TX_WAIT : ST_RX_BITS;
            end
          end
          ST_RX_BITS: begin
            if (evt.scl_rise) begin
              shreg  <= {shreg[DW-2:0], evt.sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (rx_push) begin
              state <= ST_RX_HOLD;
            end
          end
          ST_RX_HOLD: begin
            if (rx_space) begin
              sda_low <= ack_en;
              state   <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (evt.scl_fall) begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_RX_BITS;
            end
          end
          ST_TX_WAIT: begin
            if (tx_avail) begin
              shreg   <= tx_byte;
              sda_low <= ~tx_byte[DW-1];
              bitcnt  <= '0;
              state   <= ST_TX_BITS;
            end
          end
          ST_TX_BITS: begin
            if (evt.scl_fall) begin
              if (bitcnt == LAST_TX) begin
                sda_low <= 1'b0;
                state   <= ST_TX_ACK;
              end else begin
                shreg   <= {shreg[DW-2:0], 1'b0};
                sda_low <= ~shreg[DW-2];
                bitcnt  <= bitcnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (evt.scl_rise && evt.sda) begin
              nack_det <= 1'b1;
              state    <= ST_IGNORE;
            end else if (evt.scl_fall) begin
              state <= ST_TX_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_en,
  input  logic          gc_en,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          addr_match,
  output logic          gc_hit,
  output logic          dir_tx,
  output logic          stop_det,
  output logic          nack_det
);
  bus_evt_t      evt;
  logic          rx_push;
  logic          rx_space;
  logic [DW-1:0] rx_byte;
  logic          tx_pop;
  logic          tx_avail;
  logic [DW-1:0] tx_byte;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
  );

  i2c_hold_reg #(.W(DW)) u_rx_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_space), .in_data(rx_byte),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  i2c_hold_reg #(.W(DW)) u_tx_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(tx_avail), .out_ready(tx_pop), .out_data(tx_byte)
  );

  i2c_tgt_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .own_addr(own_addr), .ack_en(ack_en), .gc_en(gc_en),
    .rx_space(rx_space), .tx_avail(tx_avail), .tx_byte(tx_byte),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .addr_match(addr_match), .gc_hit(gc_hit), .dir_tx(dir_tx),
    .stop_det(stop_det), .nack_det(nack_det)
  );
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_drive_low,
  input logic          sda_drive_low,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          addr_match,
  input logic          gc_hit,
  input logic          dir_tx,
  input logic          stop_det,
  input logic          nack_det
);
  // R12
  stretch_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> addr_match);

  // R7
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R6
  rx_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && addr_match && !dir_tx) |-> scl_drive_low);

  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> (!addr_match && !gc_hit && !dir_tx));

  // R2
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stop_det);

  // R4
  gc_in_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |-> addr_match);

  // R8
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_det |-> (!sda_drive_low && !scl_drive_low));
endmodule

bind i2c_target_stretch i2c_target_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_i2c_target_stretch.sv
module sim_i2c_target_stretch;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own_addr = OWN;
  logic       ack_en = 1'b1;
  logic       gc_en = 1'b0;
  logic       rx_ready = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       scl_drive_low, sda_drive_low, rx_valid, tx_ready;
  logic       addr_match, gc_hit, dir_tx, stop_det, nack_det;
  logic [7:0] rx_data;
  logic       scl_line, sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  int stop_cnt = 0, nack_cnt = 0, str_cnt = 0;
  bit done = 1'b0;

  assign scl_line = m_scl & ~scl_drive_low;
  assign sda_line = m_sda & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_stretch u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(own_addr), .ack_en(ack_en), .gc_en(gc_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .addr_match(addr_match), .gc_hit(gc_hit), .dir_tx(dir_tx),
    .stop_det(stop_det), .nack_det(nack_det)
  );

  always @(posedge clk) begin
    if (stop_det)      stop_cnt <= stop_cnt + 1;
    if (nack_det)      nack_cnt <= nack_cnt + 1;
    if (scl_drive_low) str_cnt  <= str_cnt + 1;
  end

  typedef struct packed {
    logic [6:0] addr;
    logic       rw;
    logic       gc;
    logic       ack;
    logic [7:0] data;
    logic       exp_ack;
    logic       exp_gc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h5A, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b0},
    '{7'h5B, 1'b0, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b0},
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1},
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h42, 1'b0, 1'b0},
    '{7'h5A, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0},
    '{7'h5A, 1'b0, 1'b0, 1'b0, 8'hE7, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_cyc(QTR);
    m_scl = 1'b1; wait_high(); wait_cyc(QTR);
    m_sda = 1'b0; wait_cyc(QTR);
    m_scl = 1'b0; wait_cyc(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_cyc(QTR);
    m_scl = 1'b1; wait_high(); wait_cyc(QTR);
    m_sda = 1'b1; wait_cyc(QTR);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; wait_cyc(QTR);
    m_scl = 1'b1; wait_high(); wait_cyc(QTR);
    s = sda_line; wait_cyc(QTR);
    m_scl = 1'b0; wait_cyc(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
  endtask

  task automatic ack_slot(input logic drive, output logic acked);
    logic s;
    clock_bit(drive, s);
    acked = ~s;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] b;
    int s0, s1, k0;
    wait_cyc(4);
    // R1 reset state
    chk("R1 scl_drive_low", scl_drive_low, 0);
    chk("R1 sda_drive_low", sda_drive_low, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 flags", {addr_match, gc_hit, dir_tx, stop_det, nack_det}, 0);
    rst_n = 1'b1;
    wait_cyc(4);

    for (int v = 0; v < 6; v++) begin
      gc_en  = VECS[v].gc;
      ack_en = VECS[v].ack;
      if (VECS[v].rw) push_tx(VECS[v].data);
      s0 = str_cnt; k0 = nack_cnt;
      bus_start();
      send_byte({VECS[v].addr, VECS[v].rw});
      ack_slot(1'b1, a);
      chk("R3 R4 R5 address ack", a, VECS[v].exp_ack);
      chk("R3 addr_match", addr_match, VECS[v].exp_ack);
      chk("R4 gc_hit", gc_hit, VECS[v].exp_gc);
      if (VECS[v].exp_ack && !VECS[v].rw) begin
        send_byte(VECS[v].data);
        wait_cyc(4);
        chk("R6 rx stretch", scl_drive_low, 1);
        chk("R6 rx data", {rx_valid, rx_data}, {1'b1, VECS[v].data});
        pop_rx();
        ack_slot(1'b1, a);
        chk("R6 data ack", a, 1);
      end else if (VECS[v].exp_ack) begin
        recv_byte(b);
        chk("R8 tx byte", b, VECS[v].data);
        ack_slot(1'b1, a);
        chk("R9 nack pulse", nack_cnt - k0, 1);
      end else begin
        send_byte(VECS[v].data);
        ack_slot(1'b1, a);
        chk("R5 ignored rx", rx_valid, 0);
        chk("R5 R12 no stretch", str_cnt - s0, 0);
      end
      s1 = stop_cnt;
      bus_stop();
      wait_cyc(4);
      chk("R2 stop pulse", stop_cnt - s1, 1);
      chk("R2 flags cleared", {addr_match, gc_hit, dir_tx}, 0);
    end
    gc_en = 1'b0; ack_en = 1'b1;

    // R8 R9: stalled read, master ACK, second stall, NACK, then ignore
    bus_start();
    send_byte({OWN, 1'b1});
    ack_slot(1'b1, a);
    wait_cyc(20);
    chk("R8 tx stretch", {scl_drive_low, tx_ready, dir_tx}, 3'b111);
    push_tx(8'hA5);
    recv_byte(b);
    chk("R8 tx byte msb first", b, 8'hA5);
    ack_slot(1'b0, a);
    wait_cyc(20);
    chk("R9 stretch after master ack", scl_drive_low, 1);
    push_tx(8'h5C);
    recv_byte(b);
    chk("R9 second byte", b, 8'h5C);
    k0 = nack_cnt;
    ack_slot(1'b1, a);
    chk("R9 nack seen", nack_cnt - k0, 1);
    s0 = str_cnt;
    send_byte(8'h00);
    chk("R9 ignored after nack", {str_cnt - s0, 32'(sda_drive_low)}, 0);
    bus_stop();

    // R11: preloaded byte barely stretches
    push_tx(8'h96);
    bus_start();
    send_byte({OWN, 1'b1});
    s0 = str_cnt;
    ack_slot(1'b1, a);
    recv_byte(b);
    s1 = str_cnt;
    chk("R11 preload data", b, 8'h96);
    chk("R11 short stretch", (s1 - s0) <= 2, 1);
    ack_slot(1'b1, a);
    bus_stop();

    // R10: repeated start out of the ignoring state
    bus_start();
    send_byte({7'h11, 1'b0});
    ack_slot(1'b1, a);
    chk("R10 first addr nack", a, 0);
    bus_start();
    send_byte({OWN, 1'b0});
    ack_slot(1'b1, a);
    chk("R10 restart ack", a, 1);
    send_byte(8'h77);
    wait_cyc(4);
    chk("R10 restart rx", {rx_valid, rx_data}, {1'b1, 8'h77});
    pop_rx();
    ack_slot(1'b1, a);

    // R6 R7: held byte stays put, ack follows ack_en at read time
    send_byte(8'h12);
    wait_cyc(30);
    chk("R7 rx held", {rx_valid, rx_data, scl_drive_low}, {1'b1, 8'h12, 1'b1});
    pop_rx();
    ack_slot(1'b1, a);
    chk("R6 ack after read", a, 1);
    send_byte(8'h34);
    wait_cyc(4);
    ack_en = 1'b0;
    chk("R6 second byte", rx_data, 8'h34);
    pop_rx();
    chk("R6 consumed", rx_valid, 0);
    ack_slot(1'b1, a);
    chk("R6 nack when disabled", a, 0);
    bus_stop();
    wait_cyc(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule